// File: doc/BRIEF.md
# Clock-Loss Supervisor with Sticky Loss Flags

This block guards a chip against a dead main or sub clock. Both clocks are sampled as data by an internal RC reference clock, which is always running. For each monitored clock, a detector counts RC cycles since the last rising edge it saw. When a clock stays silent for a set number of RC cycles, the block latches a loss flag for that clock. It then forces the system clock select onto the RC source and drives a supervisor reset pulse of fixed length, so the chip restarts on the RC clock.

The loss flags are sticky. A watchdog reset leaves them set, so any restart after a watchdog reset is again on the RC clock. Only a power-on reset or the external reset pin clears them. The block also records which kind of reset happened last. Software reads the flags and the reset cause through a status word. A write port lets software request a clock source, but the flags cannot be written.

The supervisor runs a two-state machine. In `ST_WATCH` it waits for a new loss. The transition `WATCH->HOLD` fires when a detector has expired for a clock whose flag is still clear, and no pin or watchdog reset is active. In `ST_HOLD` it drives the reset pulse and counts cycles. The transition `HOLD->WATCH` fires after the last hold cycle, or at once if a pin or watchdog reset arrives.

Top module: `clk_loss_supervisor`

## Requirements
- R1: The main clock flag (status bit 0) is set when no synchronised rising edge of `main_clk_i` is seen for TIMEOUT (default 32) RC cycles. A main clock with at least one rising edge per TIMEOUT cycles never sets it.
- R2: The sub clock flag (status bit 1) follows the same rule for `sub_clk_i`, independently of the main clock flag.
- R3: Each newly set flag starts exactly one `sup_rst_o` pulse, high for HOLD_CYCLES (default 8) consecutive RC cycles. A flag that is already set never starts another pulse.
- R4: While either flag is set, `clk_sel_o` is 2'b10 (RC), whatever software has requested.
- R5: A watchdog reset (`wdt_rst_i` high) leaves both flags unchanged and sets the reset cause to 2'b10.
- R6: `ext_rst_n` low clears both flags and sets the cause to 2'b01. `por_n` low clears both flags and sets the cause to 2'b00.
- R7: The reset cause is held in status bits [3:2]: 00 for power-on, 01 for the external pin, 10 for the watchdog, 11 for a supervisor reset.
- R8: A write with `wr_addr_i`=0 stores `wr_data_i` as the requested source: 00 selects main, 01 selects sub, 10 selects RC. A write of 11 is ignored. Any reset, including the supervisor pulse, returns the request to 00. With no flag set, `clk_sel_o` equals the request.
- R9: A write with `wr_addr_i`=1 (the flag register) has no effect on the flags.
- R10: Each detector passes its clock through a two-flop synchroniser, followed by a change detector. A clock running near half the RC rate is therefore recognised as alive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rc_clk | input | 1 | Internal RC reference clock, which clocks all logic in the block |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst_n | input | 1 | External reset pin, active low, sampled on rc_clk |
| wdt_rst_i | input | 1 | Hardware watchdog reset request, active high |
| main_clk_i | input | 1 | Monitored main clock |
| sub_clk_i | input | 1 | Monitored sub clock |
| wr_en_i | input | 1 | Software write strobe |
| wr_addr_i | input | 1 | 0 selects the source-request register, 1 selects the flag register (writes to it are ignored) |
| wr_data_i | input | 2 | Write data |
| clk_sel_o | output | 2 | System clock select: 00 main, 01 sub, 10 RC |
| sup_rst_o | output | 1 | Supervisor reset pulse |
| sts_o | output | 4 | Status: [3:2] reset cause, [1] sub clock lost, [0] main clock lost |

## Verification
The assertions check on every cycle that:
- the select output stays on RC while a flag is set;
- a watchdog reset never clears a flag;
- the pin reset empties the flags;
- a flag rises only together with the start of a supervisor pulse;
- the pulse ends only after its full hold count;
- the detector counter never passes its limit.

Only the bench scenarios can show that a stopped clock is detected in time while a fast live clock is not. They also show that the pulse happens once per lost clock, that the reset-cause codes follow the sequence of resets, and that software writes are filtered.

// File: rtl/clksup_pkg.sv
package clksup_pkg;
    localparam int NUM_MON = 2;

    localparam logic [1:0] SEL_MAIN = 2'b00;
    localparam logic [1:0] SEL_SUB  = 2'b01;
    localparam logic [1:0] SEL_RC   = 2'b10;
    localparam logic [1:0] SEL_BAD  = 2'b11;

    typedef enum logic [1:0] {
        CAUSE_POR = 2'b00,
        CAUSE_PIN = 2'b01,
        CAUSE_WDT = 2'b10,
        CAUSE_SUP = 2'b11
    } rst_cause_e;

    typedef enum logic {
        ST_WATCH = 1'b0,
        ST_HOLD  = 1'b1
    } sup_state_e;
endpackage

// File: rtl/clksup_edge_mon.sv
module clksup_edge_mon #(
    parameter int TIMEOUT = 32
) (
    input  logic clk,
    input  logic por_n,
    input  logic clr_i,
    input  logic mon_i,
    output logic expired_o
);
    localparam int CNT_W = $clog2(TIMEOUT + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT);

    logic [2:0]       sync_q;
    logic [CNT_W-1:0] cnt_q;
    logic             rise;

    // two synchroniser flops, third flop feeds the change detector
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) sync_q <= '0;
        else        sync_q <= {sync_q[1:0], mon_i};
    end

    assign rise = sync_q[1] & ~sync_q[2];

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)              cnt_q <= '0;
        else if (clr_i || rise)  cnt_q <= '0;
        else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
    end

    assign expired_o = (cnt_q == LIMIT);

    assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!por_n)
        cnt_q <= LIMIT);
endmodule

// File: rtl/clksup_fsm.sv
module clksup_fsm
    import clksup_pkg::*;
#(
    parameter int HOLD_CYCLES = 8
) (
    input  logic clk,
    input  logic por_n,
    input  logic abort_i,
    input  logic loss_i,
    output logic start_o,
    output logic sup_rst_o
);
    localparam int HC_W = $clog2(HOLD_CYCLES);
    localparam logic [HC_W-1:0] LAST = HC_W'(HOLD_CYCLES - 1);

    sup_state_e      state_q, state_d;
    logic [HC_W-1:0] hold_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WATCH: if (loss_i && !abort_i) state_d = ST_HOLD;
            ST_HOLD:  if (abort_i || hold_q == LAST) state_d = ST_WATCH;
            default:  state_d = ST_WATCH;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= ST_WATCH;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            hold_q  <= (state_q == ST_HOLD && state_d == ST_HOLD) ? hold_q + 1'b1 : '0;
        end
    end

    always_comb begin
        start_o   = (state_q == ST_WATCH) && loss_i && !abort_i;
        sup_rst_o = (state_q == ST_HOLD);
    end

    // R3: a pulse not cut by another reset lasts the full hold count
    assert_hold_len_R3: assert property (@(posedge clk) disable iff (!por_n)
        ($fell(sup_rst_o) && !$past(abort_i)) |-> ($past(hold_q) == LAST));
endmodule

// File: rtl/clk_loss_supervisor.sv
module clk_loss_supervisor
    import clksup_pkg::*;
#(
    parameter int TIMEOUT     = 32,
    parameter int HOLD_CYCLES = 8
) (
    input  logic       rc_clk,
    input  logic       por_n,
    input  logic       ext_rst_n,
    input  logic       wdt_rst_i,
    input  logic       main_clk_i,
    input  logic       sub_clk_i,
    input  logic       wr_en_i,
    input  logic       wr_addr_i,
    input  logic [1:0] wr_data_i,
    output logic [1:0] clk_sel_o,
    output logic       sup_rst_o,
    output logic [3:0] sts_o
);
    logic [NUM_MON-1:0] mon_clks;
    logic [NUM_MON-1:0] expired;
    logic [NUM_MON-1:0] flags_q;
    logic               abort, clr, loss_new, start;
    rst_cause_e         cause_q;
    logic [1:0]         sel_req_q;

    assign mon_clks = {sub_clk_i, main_clk_i};
    assign abort    = !ext_rst_n || wdt_rst_i;
    assign clr      = abort || sup_rst_o;
    assign loss_new = |(expired & ~flags_q);

    for (genvar g = 0; g < NUM_MON; g++) begin : g_mon
        clksup_edge_mon #(.TIMEOUT(TIMEOUT)) u_mon (
            .clk       (rc_clk),
            .por_n     (por_n),
            .clr_i     (clr),
            .mon_i     (mon_clks[g]),
            .expired_o (expired[g])
        );
    end

    clksup_fsm #(.HOLD_CYCLES(HOLD_CYCLES)) u_fsm (
        .clk       (rc_clk),
        .por_n     (por_n),
        .abort_i   (abort),
        .loss_i    (loss_new),
        .start_o   (start),
        .sup_rst_o (sup_rst_o)
    );

    // sticky flags: only power-on or the pin clears them
    always_ff @(posedge rc_clk or negedge por_n) begin
        if (!por_n)         flags_q <= '0;
        else if (!ext_rst_n) flags_q <= '0;
        else if (start)      flags_q <= flags_q | expired;
    end

    always_ff @(posedge rc_clk or negedge por_n) begin
        if (!por_n)          cause_q <= CAUSE_POR;
        else if (!ext_rst_n) cause_q <= CAUSE_PIN;
        else if (wdt_rst_i)  cause_q <= CAUSE_WDT;
        else if (start)      cause_q <= CAUSE_SUP;
    end

    always_ff @(posedge rc_clk or negedge por_n) begin
        if (!por_n)    sel_req_q <= SEL_MAIN;
        else if (clr)  sel_req_q <= SEL_MAIN;
        else if (wr_en_i && !wr_addr_i && wr_data_i != SEL_BAD)
                       sel_req_q <= wr_data_i;
    end

    assign clk_sel_o = (|flags_q) ? SEL_RC : sel_req_q;
    assign sts_o     = {cause_q, flags_q};

    assert_sel_rc_when_lost_R4: assert property (@(posedge rc_clk) disable iff (!por_n)
        (|sts_o[1:0]) |-> (clk_sel_o == SEL_RC));

    assert_wdt_keeps_flags_R5: assert property (@(posedge rc_clk) disable iff (!por_n)
        (wdt_rst_i && ext_rst_n) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

    assert_pin_clears_flags_R6: assert property (@(posedge rc_clk) disable iff (!por_n)
        !ext_rst_n |=> (flags_q == '0));

    assert_cause_sup_R7: assert property (@(posedge rc_clk) disable iff (!por_n)
        $rose(sup_rst_o) |-> (cause_q == CAUSE_SUP));

    assert_flag_with_pulse_R2: assert property (@(posedge rc_clk) disable iff (!por_n)
        ((flags_q & ~$past(flags_q)) != '0) |-> $rose(sup_rst_o));
endmodule

// File: tb/clk_loss_supervisor_tb.sv
module clk_loss_supervisor_tb;
    logic       rc_clk = 1'b0;
    logic       por_n = 1'b0;
    logic       ext_rst_n = 1'b1;
    logic       wdt_rst_i = 1'b0;
    logic       main_clk = 1'b0;
    logic       sub_clk = 1'b0;
    logic       main_run = 1'b1;
    logic       sub_run = 1'b1;
    logic       wr_en_i = 1'b0;
    logic       wr_addr_i = 1'b0;
    logic [1:0] wr_data_i = 2'b00;
    logic [1:0] clk_sel_o;
    logic       sup_rst_o;
    logic [3:0] sts_o;

    int checks = 0;
    int failures = 0;
    int run_len = 0;
    int last_len = 0;
    int pulses = 0;

    clk_loss_supervisor u_dut (
        .rc_clk(rc_clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .wdt_rst_i(wdt_rst_i),
        .main_clk_i(main_clk), .sub_clk_i(sub_clk), .wr_en_i(wr_en_i),
        .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .clk_sel_o(clk_sel_o),
        .sup_rst_o(sup_rst_o), .sts_o(sts_o)
    );

    always #10 rc_clk = ~rc_clk;                       // 50 MHz
    always begin #23;  main_clk = main_run ? ~main_clk : 1'b0; end
    always begin #150; sub_clk  = sub_run  ? ~sub_clk  : 1'b0; end

    // measure supervisor pulses away from the active edge
    always @(negedge rc_clk) begin
        if (sup_rst_o) run_len = run_len + 1;
        else if (run_len != 0) begin
            last_len = run_len;
            pulses   = pulses + 1;
            run_len  = 0;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge rc_clk);
    endtask

    task automatic sw_write(input logic addr, input logic [1:0] data);
        @(negedge rc_clk);
        wr_en_i = 1'b1; wr_addr_i = addr; wr_data_i = data;
        @(negedge rc_clk);
        wr_en_i = 1'b0;
    endtask

    task automatic t_reset_state;
        cyc(3);
        por_n = 1'b1;
        cyc(2);
        chk("R7 cause after power-on", int'(sts_o[3:2]), 0);
        chk("R6 flags after power-on", int'(sts_o[1:0]), 0);
        chk("R8 select after power-on", int'(clk_sel_o), 0);
        chk("R3 no pulse at reset", int'(sup_rst_o), 0);
    endtask

    task automatic t_live_clocks;
        int p0 = pulses;
        cyc(200);
        chk("R10 fast main clock stays alive", int'(sts_o[0]), 0);
        chk("R2 running sub clock stays alive", int'(sts_o[1]), 0);
        chk("R1 no pulse with live clocks", pulses - p0, 0);
    endtask

    task automatic t_sw_select;
        sw_write(1'b0, 2'b01);
        chk("R8 request sub", int'(clk_sel_o), 1);
        sw_write(1'b0, 2'b11);
        chk("R8 code 11 ignored", int'(clk_sel_o), 1);
        sw_write(1'b1, 2'b11);
        cyc(1);
        chk("R9 flag write ignored", int'(sts_o[1:0]), 0);
    endtask

    task automatic t_main_loss;
        int p0 = pulses;
        main_run = 1'b0;
        cyc(60);
        chk("R1 main flag set", int'(sts_o[1:0]), 1);
        chk("R3 one pulse for main loss", pulses - p0, 1);
        chk("R3 pulse length", last_len, 8);
        chk("R7 cause supervisor", int'(sts_o[3:2]), 3);
        chk("R4 select forced to RC", int'(clk_sel_o), 2);
        sw_write(1'b0, 2'b00);
        chk("R4 request ignored while lost", int'(clk_sel_o), 2);
        sw_write(1'b1, 2'b00);
        cyc(1);
        chk("R9 flag write cannot clear", int'(sts_o[1:0]), 1);
    endtask

    task automatic t_watchdog;
        main_run = 1'b1;
        cyc(40);
        @(negedge rc_clk); wdt_rst_i = 1'b1;
        cyc(2);            wdt_rst_i = 1'b0;
        cyc(5);
        chk("R5 flags survive watchdog", int'(sts_o[1:0]), 1);
        chk("R5 cause watchdog", int'(sts_o[3:2]), 2);
        chk("R5 still on RC after watchdog", int'(clk_sel_o), 2);
    endtask

    task automatic t_pin_reset;
        int p0 = pulses;
        @(negedge rc_clk); ext_rst_n = 1'b0;
        cyc(2);            ext_rst_n = 1'b1;
        cyc(100);
        chk("R6 pin clears flags", int'(sts_o[1:0]), 0);
        chk("R7 cause pin", int'(sts_o[3:2]), 1);
        chk("R8 request back to main", int'(clk_sel_o), 0);
        chk("R6 no pulse after pin reset", pulses - p0, 0);
    endtask

    task automatic t_sub_then_main;
        int p0 = pulses;
        sub_run = 1'b0;
        cyc(80);
        chk("R2 sub flag alone", int'(sts_o[1:0]), 2);
        chk("R3 pulse for sub loss", pulses - p0, 1);
        main_run = 1'b0;
        cyc(60);
        chk("R1 both flags", int'(sts_o[1:0]), 3);
        chk("R3 second pulse for main loss", pulses - p0, 2);
        cyc(150);
        chk("R3 set flags never retrigger", pulses - p0, 2);
    endtask

    task automatic t_power_on;
        main_run = 1'b1; sub_run = 1'b1;
        @(negedge rc_clk); por_n = 1'b0;
        cyc(2);            por_n = 1'b1;
        cyc(2);
        chk("R6 power-on clears flags", int'(sts_o[1:0]), 0);
        chk("R7 cause power-on", int'(sts_o[3:2]), 0);
    endtask

    initial begin
        t_reset_state();
        t_live_clocks();
        t_sw_select();
        t_main_loss();
        t_watchdog();
        t_pin_reset();
        t_sub_then_main();
        t_power_on();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge rc_clk);
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule